// File: doc/BRIEF.md
# Prescaled 8-bit PWM Generator

This block drives a single pulse-width-modulated output from one 32-bit control word. Software writes the word through a write-enable port and can read it back at any time. The word holds a channel enable, an 8-bit clock divisor and an 8-bit low-time value. The divisor sets how many input clocks make up one step. Every PWM frame is exactly 256 steps long. Each frame opens with a low phase lasting as many steps as the low-time value, and the output is high for the rest of the frame.

A small state machine with the states IDLE, LOW and HIGH sequences each frame. Four transitions connect them. START (IDLE to LOW) fires one clock after the channel becomes active. REACH (LOW to HIGH) fires when the step count arrives at the low-time value. WRAP (HIGH to LOW) fires on the last tick of step 255. STOP (any state to IDLE) fires whenever the channel is disabled or its low-time value is zero.

Divisor and low-time values written while a frame is running go first into shadow copies. The frame logic picks them up only at START or WRAP, so no pulse is ever cut short. A divisor of zero gives the longest step, 256 clocks. A low-time value of zero switches the channel off.

Top module: `pwm8_prescaled`

## Requirements
- R1: A write with `wr_en` high stores bit 31 as the enable, bits 15:8 as the divisor value and bits 7:0 as the low-time value. `rd_data` returns these fields at the same positions, with bits 30:16 reading zero.
- R2: One step lasts N input clocks, where N is the divisor value for 1 to 255 and N is 256 when the divisor value is 0.
- R3: A frame is 256 steps long. For a low-time value D from 1 to 255, the output is low for the first D steps and high for the remaining 256−D steps, so it is high for (256−D)·N clocks per frame.
- R4: D=1 gives 255 high steps per frame, and D=255 gives one high step per frame.
- R5: When the enable is set but D=0, the output stays low and no frame runs.
- R6: When the enable bit is clear, the output is low from the next clock onward and the counters are held at zero. Re-enabling therefore starts a fresh frame.
- R7: One clock after the channel becomes active, a frame starts at step 0 in the low phase. The first rising edge of the output is therefore seen 1+D·N clocks after the write edge.
- R8: A divisor or low-time value written while the channel runs does not change the current frame. It takes effect from the next frame boundary.
- R9: A synchronous active-high reset clears the control word, both counters and the state, and drives the output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Loads `wr_data` into the control word |
| wr_data | input | 32 | Control word to write |
| rd_data | output | 32 | Readback of the control word |
| pwm_out | output | 1 | PWM output |

## Verification
The bench measures the first rising edge and the high time across whole frames for both extreme low-time values and for the wrap-around divisor of zero.

- A design that stored the low-time value as high time would invert the duty-cycle measurement.
- A design that treated a zero divisor as one would produce a frame that is 256 times too short.

A write made halfway through a frame must leave that frame unchanged. A design without shadow copies would shorten or lengthen the current pulse. Disabling the channel in the middle of a frame and then enabling it again must give a first edge at exactly 1+D·N clocks. A design that kept a stale counter would rise early.

// File: rtl/pwm8_pkg.sv
package pwm8_pkg;
    localparam int STEP_W = 8;
    localparam int WORD_W = 32;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2
    } frame_state_t;
endpackage

// File: rtl/pwm8_ctrl_reg.sv
module pwm8_ctrl_reg #(
    parameter int WORD_W  = 32,
    parameter int FIELD_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [WORD_W-1:0]  wr_data,
    output logic               en,
    output logic [FIELD_W-1:0] reload,
    output logic [FIELD_W-1:0] duty,
    output logic [WORD_W-1:0]  rd_data
);
    localparam int PAD_W = WORD_W - 1 - 2 * FIELD_W;

    logic unused_hi;
    assign unused_hi = ^wr_data[WORD_W-2:2*FIELD_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            en     <= 1'b0;
            reload <= '0;
            duty   <= '0;
        end else if (wr_en) begin
            en     <= wr_data[WORD_W-1];
            reload <= wr_data[2*FIELD_W-1:FIELD_W];
            duty   <= wr_data[FIELD_W-1:0];
        end
    end

    assign rd_data = {en, {PAD_W{1'b0}}, reload, duty};

    // R1: readback reflects the word just written, with the padding bits forced to zero
    p_readback_r1: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (rd_data == {$past(wr_data[WORD_W-1]), {PAD_W{1'b0}},
                               $past(wr_data[2*FIELD_W-1:0])}));
endmodule

// File: rtl/pwm8_prediv.sv
module pwm8_prediv #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] reload,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] term;

    // Subtracting one wraps a divisor of 0 to all ones, i.e. 2**DIV_W clocks per step
    assign term = reload - {{(DIV_W-1){1'b0}}, 1'b1};
    assign tick = run && (cnt == term);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (cnt == term) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + {{(DIV_W-1){1'b0}}, 1'b1};
        end
    end

    // R2: the count never passes the terminal value while the divisor is steady
    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (rst)
        (run && $stable(reload)) |-> (cnt <= term));
    // R2: each tick begins a fresh step
    p_tick_restart_r2: assert property (@(posedge clk) disable iff (rst)
        tick |=> (cnt == '0));
    // R6: an idle pre-divider sits at zero
    p_idle_zero_r6: assert property (@(posedge clk) disable iff (rst)
        !run |=> (cnt == '0));
endmodule

// File: rtl/pwm8_frame_fsm.sv
module pwm8_frame_fsm
    import pwm8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         active,
    input  logic         tick,
    input  logic [W-1:0] reload_in,
    input  logic [W-1:0] duty_in,
    output logic [W-1:0] reload_sh,
    output logic         run,
    output logic         pwm_high
);
    frame_state_t state, nxt;
    logic [W-1:0] step;
    logic [W-1:0] duty_sh;
    logic [W-1:0] step_inc;
    logic         frame_end;

    assign step_inc  = step + {{(W-1){1'b0}}, 1'b1};
    assign frame_end = tick && (step == {W{1'b1}});

    always_comb begin
        nxt = state;
        if (!active) begin
            nxt = ST_IDLE;                                  // STOP
        end else begin
            unique case (state)
                ST_IDLE: nxt = ST_LOW;                      // START
                ST_LOW:  if (tick && step_inc == duty_sh) nxt = ST_HIGH;  // REACH
                ST_HIGH: if (frame_end) nxt = ST_LOW;       // WRAP
                default: nxt = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            step      <= '0;
            duty_sh   <= '0;
            reload_sh <= '0;
        end else if (!active || state == ST_IDLE) begin
            step <= '0;
            if (active) begin
                duty_sh   <= duty_in;
                reload_sh <= reload_in;
            end
        end else begin
            if (tick) step <= step_inc;
            if (frame_end) begin
                duty_sh   <= duty_in;
                reload_sh <= reload_in;
            end
        end
    end

    always_comb begin
        run      = active && (state != ST_IDLE);
        pwm_high = (state == ST_HIGH);
    end

    // R7: activation leads to the low phase at step 0
    p_start_low_r7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && active) |=> (state == ST_LOW && step == '0));
    // R3: the output rises exactly when the step count meets the low-time value
    p_rise_at_duty_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(pwm_high) |-> (step == duty_sh));
    // R3: the high phase lasts until the frame wraps
    p_high_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HIGH && active && !frame_end) |=> (state == ST_HIGH));
    // R8: shadow values hold inside a running frame
    p_shadow_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (state != ST_IDLE && active && !frame_end) |=> ($stable(duty_sh) && $stable(reload_sh)));
endmodule

// File: rtl/pwm8_prescaled.sv
module pwm8_prescaled
    import pwm8_pkg::*;
#(
    parameter int DATA_W = WORD_W,
    parameter int FW     = STEP_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              pwm_out
);
    logic          en;
    logic [FW-1:0] reload;
    logic [FW-1:0] duty;
    logic [FW-1:0] reload_sh;
    logic          active;
    logic          run;
    logic          tick;
    logic          pwm_high;

    pwm8_ctrl_reg #(.WORD_W(DATA_W), .FIELD_W(FW)) i_ctrl (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .en(en), .reload(reload), .duty(duty), .rd_data(rd_data)
    );

    assign active = en && (duty != '0);

    pwm8_prediv #(.DIV_W(FW)) i_prediv (
        .clk(clk), .rst(rst), .run(run), .reload(reload_sh), .tick(tick)
    );

    pwm8_frame_fsm #(.W(FW)) i_fsm (
        .clk(clk), .rst(rst), .active(active), .tick(tick),
        .reload_in(reload), .duty_in(duty), .reload_sh(reload_sh),
        .run(run), .pwm_high(pwm_high)
    );

    assign pwm_out = pwm_high;

    // R5: a disabled channel or a zero low-time value forces the output low
    p_off_low_r5: assert property (@(posedge clk) disable iff (rst)
        !active |=> !pwm_out);
    // R9: reset clears the output and the readback
    p_reset_clear_r9: assert property (@(posedge clk)
        rst |=> (!pwm_out && rd_data == '0));
endmodule

// File: tb/test_pwm8_prescaled.sv
`timescale 1ns/1ps
module test_pwm8_prescaled;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        pwm_out;
    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    pwm8_prescaled i_pwm8_prescaled (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .pwm_out(pwm_out)
    );

    // {divisor, low-time}
    localparam logic [15:0] VEC [0:5] = '{16'h0180, 16'h0101, 16'h01FF,
                                           16'h0240, 16'h03C8, 16'h0511};

    function automatic logic [31:0] mk(input logic e, input logic [7:0] r, input logic [7:0] d);
        return {e, 15'b0, r, d};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic write_word(input logic [31:0] w);
        wr_en = 1'b1;
        wr_data = w;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // samples n = 1..ncyc after a write edge; splits counts at frame length fl
    task automatic run_window(input int ncyc, input int fl, input int mid_n,
                              input logic [31:0] mid_w,
                              output int hi1, output int hi2, output int r1, output int r2);
        hi1 = 0; hi2 = 0; r1 = -1; r2 = -1;
        for (int n = 1; n <= ncyc; n++) begin
            @(negedge clk);
            if (pwm_out) begin
                if (n <= fl) begin hi1++; if (r1 < 0) r1 = n; end
                else         begin hi2++; if (r2 < 0) r2 = n; end
            end
            if (n == mid_n) begin wr_en = 1'b1; wr_data = mid_w; end
            else wr_en = 1'b0;
        end
        wr_en = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int hi1, hi2, r1, r2;
        repeat (3) @(negedge clk);
        check(pwm_out == 1'b0, "R9", "reset output", pwm_out, 0);
        check(rd_data == 32'h0, "R9", "reset readback", rd_data, 0);
        rst = 1'b0;
        @(negedge clk);

        // R1 readback with padding bits set in the write
        write_word(32'h7FFF_ABCD);
        check(rd_data == 32'h0000_ABCD, "R1", "readback pad", rd_data, 32'h0000_ABCD);
        write_word(32'hFFFF_0000);
        check(rd_data == 32'h8000_0000, "R1", "readback en", rd_data, 32'h8000_0000);
        write_word(0);
        @(negedge clk);

        // Table: R2 R3 R4 R7
        for (int i = 0; i < 6; i++) begin
            int dv, dt;
            dv = int'(VEC[i][15:8]);
            dt = int'(VEC[i][7:0]);
            write_word(0);
            @(negedge clk);
            write_word(mk(1'b1, VEC[i][15:8], VEC[i][7:0]));
            run_window(256 * dv, 256 * dv, -1, 0, hi1, hi2, r1, r2);
            check(hi1 == (256 - dt) * dv, "R3", "high clocks per frame", hi1, (256 - dt) * dv);
            check(r1 == 1 + dt * dv, "R7", "first rise", r1, 1 + dt * dv);
        end

        // R2: divisor 0 means 256 clocks per step; R4 low-time 255
        write_word(0);
        @(negedge clk);
        write_word(mk(1'b1, 8'h00, 8'hFF));
        run_window(65536, 65536, -1, 0, hi1, hi2, r1, r2);
        check(hi1 == 256, "R2", "div256 high clocks", hi1, 256);
        check(r1 == 65281, "R2", "div256 first rise", r1, 65281);

        // R5: enabled but low-time 0
        write_word(0);
        @(negedge clk);
        write_word(mk(1'b1, 8'h01, 8'h00));
        run_window(600, 600, -1, 0, hi1, hi2, r1, r2);
        check(hi1 == 0, "R5", "zero low-time high clocks", hi1, 0);

        // R6: enable clear, then mid-frame disable and restart
        write_word(mk(1'b0, 8'h01, 8'h80));
        run_window(600, 600, -1, 0, hi1, hi2, r1, r2);
        check(hi1 == 0, "R6", "disabled high clocks", hi1, 0);
        write_word(mk(1'b1, 8'h01, 8'h0A));
        run_window(200, 200, -1, 0, hi1, hi2, r1, r2);
        write_word(mk(1'b0, 8'h01, 8'h0A));
        run_window(100, 100, -1, 0, hi1, hi2, r1, r2);
        check(hi1 == 0, "R6", "low after disable", hi1, 0);
        write_word(mk(1'b1, 8'h01, 8'h0A));
        run_window(256, 256, -1, 0, hi1, hi2, r1, r2);
        check(r1 == 11, "R6", "restart first rise", r1, 11);
        check(hi1 == 246, "R6", "restart high clocks", hi1, 246);

        // R8: mid-frame update of the low-time value
        write_word(0);
        @(negedge clk);
        write_word(mk(1'b1, 8'h02, 8'h40));
        run_window(1024, 512, 100, mk(1'b1, 8'h02, 8'hC0), hi1, hi2, r1, r2);
        check(hi1 == 384, "R8", "current frame unchanged", hi1, 384);
        check(r1 == 129, "R8", "current frame rise", r1, 129);
        check(hi2 == 128, "R8", "next frame uses new value", hi2, 128);
        check(r2 == 897, "R8", "next frame rise", r2, 897);

        // R9: reset while running
        rst = 1'b1;
        @(negedge clk);
        check(pwm_out == 1'b0, "R9", "reset mid-run output", pwm_out, 0);
        check(rd_data == 32'h0, "R9", "reset mid-run readback", rd_data, 0);
        rst = 1'b0;
        run_window(600, 600, -1, 0, hi1, hi2, r1, r2);
        check(hi1 == 0, "R9", "stays off after reset", hi1, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule